// File: doc/BRIEF.md
# Coherent Snoop Bus Hub

This block is the shared interconnect that sits between several coherent private caches and a single memory port. Each cache raises a bus request carrying one of four commands: a read, a read-for-ownership, an ownership upgrade of a line it already holds, or a write-back of a dirty evicted line. The hub grants one request at a time, rotating priority among the caches. It holds that grant until the transaction finishes, which places every bus transaction in one global order.

For every granted request except a write-back, the hub shows a snoop (command and address) to every cache other than the requester. It waits until each of those caches has acknowledged, and merges their "I keep a copy" and "I am flushing dirty data" answers. Line data goes back to the requester from the flushing cache when one flushed, and from memory otherwise. When dirty data is flushed on a plain read, the same data is also written to memory, so memory is current while the line is held shared. An upgrade moves no data and touches no memory.

The completion pulse tells the requester that the transaction is over. On a read, the merged shared flag that comes with it tells the requester whether to install the line as Exclusive (flag low) or as Shared (flag high).

Top module: `snoop_bus_hub`

## Requirements
- R1: While reset is held and in the first cycle after it, grant, done, snoop-valid and memory-request outputs are all zero.
- R2: Among requests pending together, the grant goes to the first requesting cache after the one granted last, wrapping around; after reset the search starts at cache 0.
- R3: At most one grant is active. It stays constant until its done pulse, and the next grant is issued only after the previous transaction (including its snoop) is complete, so two same-cycle requests for one line are serialized.
- R4: For commands 0, 1 and 2, snoop-valid is raised for every cache except the requester, with the granted command and address. It stays raised for each cache until that cache acknowledges, and the transaction does not complete before all have acknowledged.
- R5: A read (command 0) with no flushing snooper reads memory at the request address and returns that data. Its shared flag is the OR of the acknowledging snoopers' shared answers.
- R6: A read (command 0) during which a snooper flushes returns the flushed data, reports shared high, and writes the flushed data to memory at the request address without reading memory.
- R7: A read-for-ownership (command 1) returns the flushed data with no memory access when a snooper flushes, and otherwise returns data read from memory.
- R8: An upgrade (command 2) performs no memory access and completes only after every other cache has acknowledged.
- R9: A write-back (command 3) raises no snoop and writes the request's data to memory at its address, completing after the memory acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid_i | input | N | Per-cache request pending; held until that cache's done pulse |
| req_cmd_i | input | 2*N | Per-cache command: 0 read, 1 read-for-ownership, 2 upgrade, 3 write-back |
| req_addr_i | input | N*ADDR_W | Per-cache line address |
| req_wdata_i | input | N*LINE_W | Per-cache write-back line data |
| grant_o | output | N | One-hot grant, held for the whole transaction |
| done_o | output | N | One-cycle completion pulse to the granted cache |
| resp_data_o | output | LINE_W | Line data for the requester, valid with done |
| resp_shared_o | output | 1 | For reads: install as Shared when high, Exclusive when low |
| snp_valid_o | output | N | Per-cache snoop request, held until acknowledged |
| snp_cmd_o | output | 2 | Command being snooped |
| snp_addr_o | output | ADDR_W | Address being snooped |
| snp_ack_i | input | N | Per-cache snoop acknowledge |
| snp_shared_i | input | N | Per-cache "copy retained" answer, read with acknowledge |
| snp_flush_i | input | N | Per-cache "flushing dirty data" answer, read with acknowledge |
| snp_data_i | input | N*LINE_W | Per-cache flushed line data |
| mem_req_o | output | 1 | Memory access request, held until acknowledged |
| mem_we_o | output | 1 | Memory access is a write |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_wdata_o | output | LINE_W | Memory write data |
| mem_rdata_i | input | LINE_W | Memory read data, valid with acknowledge |
| mem_ack_i | input | 1 | Memory acknowledge |

## Verification
Arbitration and snooping collide when two caches request the same line in the same cycle. The bench provokes this with two reads to one address raised together. The first requester must receive its completion before it ever sees a snoop for the second, and the second must come back flagged shared while the first came back exclusive. A second overlap occurs when a flushing snooper answers during a read, so that a memory write and the response to the requester come from the same transaction. The bench judges this by checking that the flushed value appears both in the response and in the memory model, and that memory was never read.

// File: rtl/snoop_bus_pkg.sv
`timescale 1ns/1ps
package snoop_bus_pkg;
    typedef enum logic [1:0] {
        CMD_RD   = 2'd0,
        CMD_RDX  = 2'd1,
        CMD_UPGR = 2'd2,
        CMD_WB   = 2'd3
    } bus_cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SNOOP = 2'd1,
        ST_MEM   = 2'd2,
        ST_DONE  = 2'd3
    } hub_state_e;
endpackage

// File: rtl/snoop_rr_pick.sv
`timescale 1ns/1ps
module snoop_rr_pick #(
    parameter int N  = 3,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req_i,
    input  logic [IW-1:0] last_i,
    output logic          found_o,
    output logic [IW-1:0] idx_o
);
    int cand;

    // Scan from farthest to nearest so the nearest requester after last_i wins.
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        cand    = 0;
        for (int k = N; k >= 1; k--) begin
            cand = (int'(last_i) + k) % N;
            if (req_i[cand]) begin
                found_o = 1'b1;
                idx_o   = IW'(cand);
            end
        end
    end
endmodule

// File: rtl/snoop_resp_merge.sv
`timescale 1ns/1ps
module snoop_resp_merge #(
    parameter int N      = 3,
    parameter int LINE_W = 64
) (
    input  logic [N-1:0]        pend_i,
    input  logic [N-1:0]        ack_i,
    input  logic [N-1:0]        shr_i,
    input  logic [N-1:0]        fls_i,
    input  logic [N*LINE_W-1:0] data_i,
    output logic [N-1:0]        ackm_o,
    output logic                shr_o,
    output logic                fls_o,
    output logic [LINE_W-1:0]   data_o
);
    // Only answers from caches still owing an acknowledge are taken.
    always_comb begin
        ackm_o = pend_i & ack_i;
        shr_o  = |(ackm_o & shr_i);
        fls_o  = |(ackm_o & fls_i);
        data_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (ackm_o[i] && fls_i[i]) begin
                data_o = data_i[i*LINE_W +: LINE_W];
            end
        end
    end
endmodule

// File: rtl/snoop_bus_hub.sv
`timescale 1ns/1ps
module snoop_bus_hub
    import snoop_bus_pkg::*;
#(
    parameter int N      = 3,
    parameter int ADDR_W = 16,
    parameter int LINE_W = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N-1:0]        req_valid_i,
    input  logic [2*N-1:0]      req_cmd_i,
    input  logic [N*ADDR_W-1:0] req_addr_i,
    input  logic [N*LINE_W-1:0] req_wdata_i,
    output logic [N-1:0]        grant_o,
    output logic [N-1:0]        done_o,
    output logic [LINE_W-1:0]   resp_data_o,
    output logic                resp_shared_o,
    output logic [N-1:0]        snp_valid_o,
    output logic [1:0]          snp_cmd_o,
    output logic [ADDR_W-1:0]   snp_addr_o,
    input  logic [N-1:0]        snp_ack_i,
    input  logic [N-1:0]        snp_shared_i,
    input  logic [N-1:0]        snp_flush_i,
    input  logic [N*LINE_W-1:0] snp_data_i,
    output logic                mem_req_o,
    output logic                mem_we_o,
    output logic [ADDR_W-1:0]   mem_addr_o,
    output logic [LINE_W-1:0]   mem_wdata_o,
    input  logic [LINE_W-1:0]   mem_rdata_i,
    input  logic                mem_ack_i
);
    localparam int IW = (N > 1) ? $clog2(N) : 1;

    typedef struct packed {
        hub_state_e         st;
        logic [N-1:0]       gnt;
        logic [IW-1:0]      last;
        bus_cmd_e           cmd;
        logic [ADDR_W-1:0]  addr;
        logic [LINE_W-1:0]  data;
        logic [N-1:0]       pend;
        logic               shr;
        logic               fls;
    } hub_regs_t;

    hub_regs_t d, q;

    logic              pick_found;
    logic [IW-1:0]     pick_idx;
    logic [N-1:0]      ackm;
    logic              m_shr, m_fls;
    logic [LINE_W-1:0] m_data;
    logic [N-1:0]      pend_left;
    logic              fls_now;

    snoop_rr_pick #(.N(N), .IW(IW)) u_pick (
        .req_i   (req_valid_i),
        .last_i  (q.last),
        .found_o (pick_found),
        .idx_o   (pick_idx)
    );

    snoop_resp_merge #(.N(N), .LINE_W(LINE_W)) u_merge (
        .pend_i (q.pend),
        .ack_i  (snp_ack_i),
        .shr_i  (snp_shared_i),
        .fls_i  (snp_flush_i),
        .data_i (snp_data_i),
        .ackm_o (ackm),
        .shr_o  (m_shr),
        .fls_o  (m_fls),
        .data_o (m_data)
    );

    always_comb begin
        d         = q;
        pend_left = q.pend & ~ackm;
        fls_now   = q.fls | m_fls;
        case (q.st)
            ST_IDLE: begin
                if (pick_found) begin
                    d.gnt           = '0;
                    d.gnt[pick_idx] = 1'b1;
                    d.last          = pick_idx;
                    d.cmd           = bus_cmd_e'(req_cmd_i[pick_idx*2 +: 2]);
                    d.addr          = req_addr_i[pick_idx*ADDR_W +: ADDR_W];
                    d.data          = req_wdata_i[pick_idx*LINE_W +: LINE_W];
                    d.shr           = 1'b0;
                    d.fls           = 1'b0;
                    if (d.cmd == CMD_WB) begin
                        d.pend = '0;
                        d.st   = ST_MEM;
                    end else begin
                        d.pend           = '1;
                        d.pend[pick_idx] = 1'b0;
                        d.st             = ST_SNOOP;
                    end
                end
            end
            ST_SNOOP: begin
                d.pend = pend_left;
                d.shr  = q.shr | m_shr;
                d.fls  = fls_now;
                if (m_fls) begin
                    d.data = m_data;
                end
                if (pend_left == '0) begin
                    if (q.cmd == CMD_UPGR) begin
                        d.st = ST_DONE;
                    end else if (fls_now) begin
                        d.st = (q.cmd == CMD_RD) ? ST_MEM : ST_DONE;
                    end else begin
                        d.st = ST_MEM;
                    end
                end
            end
            ST_MEM: begin
                if (mem_ack_i) begin
                    if (!mem_we_o) begin
                        d.data = mem_rdata_i;
                    end
                    d.st = ST_DONE;
                end
            end
            default: begin
                d.gnt = '0;
                d.st  = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_IDLE;
            q.last <= IW'(N - 1);
            q.cmd  <= CMD_RD;
        end else begin
            q <= d;
        end
    end

    assign grant_o       = q.gnt;
    assign done_o        = (q.st == ST_DONE) ? q.gnt : '0;
    assign resp_data_o   = q.data;
    assign resp_shared_o = (q.cmd == CMD_RD) && (q.shr || q.fls);
    assign snp_valid_o   = (q.st == ST_SNOOP) ? q.pend : '0;
    assign snp_cmd_o     = q.cmd;
    assign snp_addr_o    = q.addr;
    assign mem_req_o     = (q.st == ST_MEM);
    assign mem_we_o      = (q.cmd == CMD_WB) || q.fls;
    assign mem_addr_o    = q.addr;
    assign mem_wdata_o   = q.data;

    // R3: a single grant, held steady until its completion pulse.
    a_r3_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o));
    a_r3_grant_held: assert property (@(posedge clk) disable iff (!rst_n)
        (|grant_o && !(|done_o)) |=> (grant_o == $past(grant_o)));
    a_r3_done_to_grantee: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o & ~grant_o) == '0);
    // R4: the requester is never snooped by its own transaction.
    a_r4_no_self_snoop: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid_o & grant_o) == '0);
    // R4: snooping and completion never overlap.
    a_r4_acks_before_done: assert property (@(posedge clk) disable iff (!rst_n)
        (|done_o) |-> (snp_valid_o == '0));
    // R8: upgrades stay off the memory port.
    a_r8_upgr_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
        (|grant_o && q.cmd == CMD_UPGR) |-> !mem_req_o);
    // R9: write-backs raise no snoop and only write memory.
    a_r9_wb_no_snoop: assert property (@(posedge clk) disable iff (!rst_n)
        (|grant_o && q.cmd == CMD_WB) |-> (snp_valid_o == '0 && (!mem_req_o || mem_we_o)));
    // R5: the memory request holds its address until acknowledged.
    a_r5_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o)));
endmodule

// File: tb/test_snoop_bus_hub.sv
`timescale 1ns/1ps
module test_snoop_bus_hub;
    localparam int N  = 3;
    localparam int AW = 16;
    localparam int LW = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [N-1:0]    req_valid = '0;
    logic [2*N-1:0]  req_cmd = '0;
    logic [N*AW-1:0] req_addr = '0;
    logic [N*LW-1:0] req_wdata = '0;
    logic [N-1:0]    grant, done, snp_valid;
    logic [LW-1:0]   resp_data;
    logic            resp_shared;
    logic [1:0]      snp_cmd;
    logic [AW-1:0]   snp_addr;
    logic [N-1:0]    snp_ack = '0, snp_shared = '0, snp_flush = '0;
    logic [N*LW-1:0] snp_data = '0;
    logic            mem_req, mem_we, mem_ack = 1'b0;
    logic [AW-1:0]   mem_addr;
    logic [LW-1:0]   mem_wdata, mem_rdata = '0;

    snoop_bus_hub #(.N(N), .ADDR_W(AW), .LINE_W(LW)) i_snoop_bus_hub (
        .clk(clk), .rst_n(rst_n),
        .req_valid_i(req_valid), .req_cmd_i(req_cmd), .req_addr_i(req_addr),
        .req_wdata_i(req_wdata), .grant_o(grant), .done_o(done),
        .resp_data_o(resp_data), .resp_shared_o(resp_shared),
        .snp_valid_o(snp_valid), .snp_cmd_o(snp_cmd), .snp_addr_o(snp_addr),
        .snp_ack_i(snp_ack), .snp_shared_i(snp_shared), .snp_flush_i(snp_flush),
        .snp_data_i(snp_data), .mem_req_o(mem_req), .mem_we_o(mem_we),
        .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
        .mem_ack_i(mem_ack)
    );

    int n_chk = 0, n_bad = 0, cyc = 0;
    bit wd = 1'b0;
    logic [LW-1:0] mem [16];
    int mem_rd_n, mem_wr_n;
    logic [AW-1:0] wr_addr;
    logic [LW-1:0] wr_data;
    logic [N-1:0] seen_mask;
    logic [1:0]   seen_cmd;
    logic [AW-1:0] seen_addr;
    int done_cyc [N], first_snp [N], ack_cyc [N], cnt [N];
    logic [LW-1:0] r_data [N];
    logic r_shr [N];
    int ord [8];
    int ord_n;
    bit sh_en [N], fl_en [N];
    logic [LW-1:0] fl_dat [N];
    int dly [N];

    function automatic logic [LW-1:0] init_val(int a);
        return 64'h0000_1000_0000_0000 + LW'(a) * 64'h11;
    endfunction

    task automatic chk(string tag, logic [LW-1:0] act, logic [LW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic clear_log();
        mem_rd_n = 0; mem_wr_n = 0; wr_addr = '0; wr_data = '0;
        seen_mask = '0; seen_cmd = '0; seen_addr = '0; ord_n = 0;
        for (int i = 0; i < N; i++) begin
            done_cyc[i] = -1; first_snp[i] = -1; ack_cyc[i] = -1;
            r_data[i] = '0; r_shr[i] = 1'b0;
            sh_en[i] = 1'b0; fl_en[i] = 1'b0; fl_dat[i] = '0; dly[i] = 0;
        end
    endtask

    // One cycle of all external models, evaluated at the falling edge.
    task automatic tick();
        @(negedge clk);
        cyc++;
        if (cyc > 20000 && !wd) begin
            wd = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual %0d expected %0d", cyc, 20000);
        end
        if (mem_ack) begin
            mem_ack = 1'b0;
        end else if (mem_req) begin
            if (mem_we) begin
                mem[mem_addr[3:0]] = mem_wdata;
                mem_wr_n++; wr_addr = mem_addr; wr_data = mem_wdata;
            end else begin
                mem_rdata = mem[mem_addr[3:0]];
                mem_rd_n++;
            end
            mem_ack = 1'b1;
        end
        for (int i = 0; i < N; i++) begin
            snp_ack[i] = 1'b0; snp_shared[i] = 1'b0; snp_flush[i] = 1'b0;
            if (snp_valid[i]) begin
                seen_mask[i] = 1'b1; seen_cmd = snp_cmd; seen_addr = snp_addr;
                if (first_snp[i] < 0) first_snp[i] = cyc;
                if (cnt[i] >= dly[i]) begin
                    snp_ack[i] = 1'b1; snp_shared[i] = sh_en[i]; snp_flush[i] = fl_en[i];
                    snp_data[i*LW +: LW] = fl_dat[i];
                    ack_cyc[i] = cyc;
                end
                cnt[i]++;
            end else begin
                cnt[i] = 0;
            end
            if (done[i]) begin
                done_cyc[i] = cyc; r_data[i] = resp_data; r_shr[i] = resp_shared;
                if (ord_n < 8) ord[ord_n] = i;
                ord_n++;
                req_valid[i] = 1'b0;
            end
        end
    endtask

    task automatic set_req(int i, logic [1:0] c, int a, logic [LW-1:0] w);
        req_cmd[i*2 +: 2] = c;
        req_addr[i*AW +: AW] = AW'(a);
        req_wdata[i*LW +: LW] = w;
        req_valid[i] = 1'b1;
    endtask

    task automatic run_all();
        tick();
        while ((req_valid != '0 || grant != '0) && !wd) tick();
    endtask

    task automatic t_reset();
        chk("R1 grant", LW'(grant), '0);
        chk("R1 done", LW'(done), '0);
        chk("R1 snoop", LW'(snp_valid), '0);
        chk("R1 memreq", LW'(mem_req), '0);
    endtask

    task automatic t_writeback();
        clear_log();
        set_req(2, 2'd3, 5, 64'hDEAD_BEEF_0000_0005);
        run_all();
        chk("R9 wb written", mem[5], 64'hDEAD_BEEF_0000_0005);
        chk("R9 wb writes", LW'(mem_wr_n), 1);
        chk("R9 wb no snoop", LW'(seen_mask), '0);
        chk("R9 wb done", LW'(done_cyc[2] > 0), 1);
    endtask

    task automatic t_race();
        clear_log();
        sh_en[0] = 1'b1;
        set_req(0, 2'd0, 3, '0);
        set_req(1, 2'd0, 3, '0);
        run_all();
        chk("R2 race first", LW'(ord[0]), 0);
        chk("R2 race second", LW'(ord[1]), 1);
        chk("R3 serialized", LW'(first_snp[0] > done_cyc[0]), 1);
        chk("R5 first data", r_data[0], init_val(3));
        chk("R5 first exclusive", LW'(r_shr[0]), 0);
        chk("R5 second data", r_data[1], init_val(3));
        chk("R5 second shared", LW'(r_shr[1]), 1);
        chk("R5 mem reads", LW'(mem_rd_n), 2);
    endtask

    task automatic t_read_flush();
        clear_log();
        fl_en[2] = 1'b1; fl_dat[2] = 64'hF1F1_0000_0000_0007;
        set_req(1, 2'd0, 7, '0);
        run_all();
        chk("R4 snoop mask", LW'(seen_mask), 3'b101);
        chk("R4 snoop cmd", LW'(seen_cmd), 0);
        chk("R4 snoop addr", LW'(seen_addr), 7);
        chk("R6 data", r_data[1], 64'hF1F1_0000_0000_0007);
        chk("R6 shared", LW'(r_shr[1]), 1);
        chk("R6 mem updated", mem[7], 64'hF1F1_0000_0000_0007);
        chk("R6 wr addr", LW'(wr_addr), 7);
        chk("R6 no mem read", LW'(mem_rd_n), 0);
    endtask

    task automatic t_rdx_flush();
        clear_log();
        fl_en[0] = 1'b1; fl_dat[0] = 64'hABCD_0000_0000_0009;
        set_req(2, 2'd1, 9, '0);
        run_all();
        chk("R4 rdx mask", LW'(seen_mask), 3'b011);
        chk("R7 flush data", r_data[2], 64'hABCD_0000_0000_0009);
        chk("R7 no mem access", LW'(mem_rd_n + mem_wr_n), 0);
        chk("R7 mem untouched", mem[9], init_val(9));
    endtask

    task automatic t_rdx_mem();
        clear_log();
        set_req(1, 2'd1, 4, '0);
        run_all();
        chk("R7 mem data", r_data[1], init_val(4));
        chk("R7 one read", LW'(mem_rd_n), 1);
        chk("R7 no write", LW'(mem_wr_n), 0);
    endtask

    task automatic t_upgrade();
        clear_log();
        dly[1] = 4;
        set_req(0, 2'd2, 6, '0);
        run_all();
        chk("R8 no mem", LW'(mem_rd_n + mem_wr_n), 0);
        chk("R8 snoop cmd", LW'(seen_cmd), 2);
        chk("R4 waits slow ack", LW'(done_cyc[0] > ack_cyc[1]), 1);
        chk("R8 slow ack late", LW'(ack_cyc[1] >= first_snp[1] + 4), 1);
    endtask

    task automatic t_rotate();
        clear_log();
        set_req(0, 2'd0, 1, '0);
        set_req(1, 2'd0, 2, '0);
        set_req(2, 2'd0, 8, '0);
        run_all();
        // last grant was cache 0, so the rotation continues at cache 1
        chk("R2 rot 0", LW'(ord[0]), 1);
        chk("R2 rot 1", LW'(ord[1]), 2);
        chk("R2 rot 2", LW'(ord[2]), 0);
        chk("R5 rot data", r_data[2], init_val(8));
    endtask

    initial begin
        for (int a = 0; a < 16; a++) mem[a] = init_val(a);
        for (int i = 0; i < N; i++) cnt[i] = 0;
        clear_log();
        rst_n = 1'b0;
        for (int k = 0; k < 4; k++) tick();
        t_reset();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_writeback();
        t_race();
        t_read_flush();
        t_rdx_flush();
        t_rdx_mem();
        t_upgrade();
        t_rotate();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule